// File: doc/BRIEF.md
# Six-Input Look-Up Table with Always-Live Partial Outputs

This block is a six-input look-up table whose single selection tree is tapped at three depths. The 64-entry truth table is held in a serial configuration chain, loaded one bit per clock while the load enable is high. The six data inputs drive the tree directly at all times. Nothing forces, gates or masks them, and no configuration bit picks an operating mode.

Five function outputs are valid at the same time. Two come from the fourth tree level and act as 4-input functions. Two come from the fifth level and act as 5-input functions. One comes from the root and is the full 6-input function. A packing tool can use any subset of these results without reconfiguring the block.

The chain output presents the oldest stored bit. Several blocks can therefore be strung into one longer configuration chain.

Top module: `lut6_frac_top`

## Requirements
- R1: With `rst` high at a rising edge of `clk`, all 64 stored bits become 0. After that, every function output and `cfg_dout` read 0 for all input values.
- R2: At each rising edge with `cfg_en` high, `cfg_din` is written into stored bit 63 and every stored bit i (1..63) moves to bit i-1. `cfg_dout` always shows stored bit 0. The first bit of 64 consecutive shifts therefore ends in bit 0, and the last bit ends in bit 63.
- R3: At a rising edge with `cfg_en` low, no stored bit changes, whatever `cfg_din` carries.
- R4: `lut6_out` equals stored bit k, where k is `din` read as an unsigned number with `din[0]` as its LSB.
- R5: `lut5_lo` equals stored bit `din[4:0]`. `lut5_hi` equals stored bit 32 + `din[4:0]`. Neither depends on `din[5]`.
- R6: `lut4_lo` equals stored bit `din[3:0]`. `lut4_hi` equals stored bit 16 + `din[3:0]`. Neither depends on `din[5:4]`.
- R7: All five function outputs follow `din` combinationally within the same cycle and are valid simultaneously. There are no configuration bits beyond the 64 table bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Configuration clock |
| rst | input | 1 | Synchronous active-high clear of the table |
| cfg_en | input | 1 | Shift enable for the configuration chain |
| cfg_din | input | 1 | Serial configuration data in |
| din | input | 6 | Function inputs, bit 0 nearest the table |
| lut4_lo | output | 1 | 4-input result over table bits 0..15 |
| lut4_hi | output | 1 | 4-input result over table bits 16..31 |
| lut5_lo | output | 1 | 5-input result over table bits 0..31 |
| lut5_hi | output | 1 | 5-input result over table bits 32..63 |
| lut6_out | output | 1 | Full 6-input result |
| cfg_dout | output | 1 | Serial configuration data out (stored bit 0) |

## Verification
The hard case is showing that every one of the 64 stored bits reaches each tap it belongs to. A random table only checks an address whose bit differs from its neighbours, and a wrong select polarity or a swapped tap can go unnoticed when neighbouring bits agree. The stimulus adds one-hot tables placed at the tap boundaries (bits 0, 15, 16, 31, 32, 63) and alternating patterns next to random tables. Each table is swept over all 64 input values. After loading, the chain is drained so that every stored bit is read back serially in order.

// File: rtl/lut6_frac_pkg.sv
package lut6_frac_pkg;

    localparam int unsigned NUM_IN   = 6;
    localparam int unsigned CFG_BITS = 1 << NUM_IN;

    // Outputs taken from the shared selection tree.
    typedef struct packed {
        logic lut4_lo;
        logic lut4_hi;
        logic lut5_lo;
        logic lut5_hi;
        logic lut6;
    } lut_taps_t;

    // Flat position of the first node of a tree level; level 0 holds the table.
    function automatic int unsigned level_base(input int unsigned level,
                                               input int unsigned leaves);
        return 2 * leaves - ((2 * leaves) >> level);
    endfunction

    function automatic int unsigned tree_nodes(input int unsigned leaves);
        return 2 * leaves - 1;
    endfunction

endpackage

// File: rtl/lut_mux2.sv
module lut_mux2 (
    input  logic a0,
    input  logic a1,
    input  logic sel,
    output logic y
);
    assign y = sel ? a1 : a0;
endmodule

// File: rtl/cfg_shift_chain.sv
module cfg_shift_chain #(
    parameter int unsigned WIDTH = 64
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             shift_en,
    input  logic             ser_in,
    output logic             ser_out,
    output logic [WIDTH-1:0] store
);
    always_ff @(posedge clk) begin
        if (rst) begin
            store <= '0;
        end else if (shift_en) begin
            store <= {ser_in, store[WIDTH-1:1]};
        end
    end

    assign ser_out = store[0];

    p_clear_r1: assert property (@(posedge clk) rst |=> (store == '0))
        else $error("stored bits not cleared by reset");

    p_entry_r2: assert property (@(posedge clk) disable iff (rst)
        shift_en |=> (store[WIDTH-1] == $past(ser_in)))
        else $error("serial input not captured at top of chain");

    p_exit_r2: assert property (@(posedge clk) disable iff (rst)
        shift_en |=> (ser_out == $past(store[1])))
        else $error("chain output did not advance");

    p_hold_r3: assert property (@(posedge clk) disable iff (rst)
        !shift_en |=> $stable(store))
        else $error("stored bits changed without enable");
endmodule

// File: rtl/lut_sel_tree.sv
module lut_sel_tree
    import lut6_frac_pkg::*;
#(
    parameter int unsigned K = 6
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [(1<<K)-1:0]   table_bits,
    input  logic [K-1:0]        sel,
    output logic [2*(1<<K)-2:0] nodes
);
    localparam int unsigned LEAVES = 1 << K;
    localparam int unsigned TOTAL  = 2 * LEAVES - 1;
    localparam int unsigned ROOT   = TOTAL - 1;

    assign nodes[LEAVES-1:0] = table_bits;

    for (genvar lv = 1; lv <= K; lv++) begin : g_level
        localparam int unsigned CUR  = level_base(lv, LEAVES);
        localparam int unsigned PREV = level_base(lv - 1, LEAVES);
        for (genvar j = 0; j < (LEAVES >> lv); j++) begin : g_node
            lut_mux2 u_mux (
                .a0  (nodes[PREV + 2*j]),
                .a1  (nodes[PREV + 2*j + 1]),
                .sel (sel[lv-1]),
                .y   (nodes[CUR + j])
            );
        end
    end

    p_root_r4: assert property (@(posedge clk) disable iff (rst)
        nodes[ROOT] == table_bits[sel])
        else $error("tree root disagrees with direct table lookup");
endmodule

// File: rtl/lut6_frac_top.sv
module lut6_frac_top
    import lut6_frac_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_en,
    input  logic              cfg_din,
    input  logic [NUM_IN-1:0] din,
    output logic              lut4_lo,
    output logic              lut4_hi,
    output logic              lut5_lo,
    output logic              lut5_hi,
    output logic              lut6_out,
    output logic              cfg_dout
);
    localparam int unsigned NODES = tree_nodes(CFG_BITS);
    localparam int unsigned OFF4  = level_base(NUM_IN - 2, CFG_BITS);
    localparam int unsigned OFF5  = level_base(NUM_IN - 1, CFG_BITS);
    localparam int unsigned OFF6  = level_base(NUM_IN, CFG_BITS);

    logic [CFG_BITS-1:0] table_q;
    logic [NODES-1:0]    node_v;
    lut_taps_t           taps;

    cfg_shift_chain #(.WIDTH(CFG_BITS)) u_chain (
        .clk      (clk),
        .rst      (rst),
        .shift_en (cfg_en),
        .ser_in   (cfg_din),
        .ser_out  (cfg_dout),
        .store    (table_q)
    );

    lut_sel_tree #(.K(NUM_IN)) u_tree (
        .clk        (clk),
        .rst        (rst),
        .table_bits (table_q),
        .sel        (din),
        .nodes      (node_v)
    );

    always_comb begin
        taps.lut4_lo = node_v[OFF4];
        taps.lut4_hi = node_v[OFF4 + 1];
        taps.lut5_lo = node_v[OFF5];
        taps.lut5_hi = node_v[OFF5 + 1];
        taps.lut6    = node_v[OFF6];
    end

    assign lut4_lo  = taps.lut4_lo;
    assign lut4_hi  = taps.lut4_hi;
    assign lut5_lo  = taps.lut5_lo;
    assign lut5_hi  = taps.lut5_hi;
    assign lut6_out = taps.lut6;

    p_root_compose_r4: assert property (@(posedge clk) disable iff (rst)
        lut6_out == (din[NUM_IN-1] ? lut5_hi : lut5_lo))
        else $error("root output not built from the 5-input taps");

    p_five_compose_r5: assert property (@(posedge clk) disable iff (rst)
        lut5_lo == (din[NUM_IN-2] ? lut4_hi : lut4_lo))
        else $error("low 5-input tap not built from the 4-input taps");

    p_four_lookup_r6: assert property (@(posedge clk) disable iff (rst)
        lut4_hi == table_q[{2'b01, din[NUM_IN-3:0]}])
        else $error("upper 4-input tap wrong");
endmodule

// File: tb/tb_lut6_frac_top.sv
module tb_lut6_frac_top;
    localparam time CLK_PERIOD = 10ns;
    localparam int  WATCHDOG   = 50000;

    logic       clk = 1'b0;
    logic       rst;
    logic       cfg_en;
    logic       cfg_din;
    logic [5:0] din;
    logic       lut4_lo, lut4_hi, lut5_lo, lut5_hi, lut6_out, cfg_dout;

    int checks   = 0;
    int failures = 0;
    int cycles   = 0;
    bit done     = 0;

    lut6_frac_top dut (
        .clk      (clk),
        .rst      (rst),
        .cfg_en   (cfg_en),
        .cfg_din  (cfg_din),
        .din      (din),
        .lut4_lo  (lut4_lo),
        .lut4_hi  (lut4_hi),
        .lut5_lo  (lut5_lo),
        .lut5_hi  (lut5_hi),
        .lut6_out (lut6_out),
        .cfg_dout (cfg_dout)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input string what,
                         input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
        end
    endtask

    function automatic logic ref6(input logic [63:0] t, input logic [5:0] a);
        return t[a];
    endfunction
    function automatic logic ref5(input logic [63:0] t, input logic hi, input logic [4:0] a);
        return t[{hi, a}];
    endfunction
    function automatic logic ref4(input logic [63:0] t, input logic hi, input logic [3:0] a);
        return t[{1'b0, hi, a}];
    endfunction

    // Shift the table in, bit 0 first (R2).
    task automatic load(input logic [63:0] t);
        for (int i = 0; i < 64; i++) begin
            @(negedge clk);
            cfg_din = t[i];
            cfg_en  = 1'b1;
        end
        @(negedge clk);
        cfg_en = 1'b0;
    endtask

    // Sweep all 64 input values between edges (R4, R5, R6, R7).
    task automatic sweep(input logic [63:0] t, input string tag);
        for (int a = 0; a < 64; a++) begin
            din = a[5:0];
            #1;
            check("R4", {tag, " lut6_out"}, lut6_out, ref6(t, din));
            check("R5", {tag, " lut5_lo"},  lut5_lo,  ref5(t, 1'b0, din[4:0]));
            check("R5", {tag, " lut5_hi"},  lut5_hi,  ref5(t, 1'b1, din[4:0]));
            check("R6", {tag, " lut4_lo"},  lut4_lo,  ref4(t, 1'b0, din[3:0]));
            check("R6", {tag, " lut4_hi"},  lut4_hi,  ref4(t, 1'b1, din[3:0]));
        end
    endtask

    // Drain the chain: each stored bit appears on cfg_dout in order (R2).
    task automatic drain(input logic [63:0] t);
        for (int i = 0; i < 64; i++) begin
            @(negedge clk);
            check("R2", "cfg_dout drain", cfg_dout, t[i]);
            cfg_din = 1'b0;
            cfg_en  = 1'b1;
        end
        @(negedge clk);
        cfg_en = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG && !done) begin
            failures++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    initial begin
        logic [63:0] t;
        logic [63:0] pats [10];
        void'($urandom(32'd1234));
        rst = 1'b1; cfg_en = 1'b0; cfg_din = 1'b0; din = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: cleared table
        check("R1", "cfg_dout after reset", cfg_dout, 1'b0);
        sweep(64'h0, "R1 reset");

        pats[0] = '1;
        pats[1] = 64'hAAAA_AAAA_AAAA_AAAA;
        pats[2] = 64'h1;
        pats[3] = 64'h8000_0000_0000_0000;
        pats[4] = 64'h1 << 15;
        pats[5] = 64'h1 << 16;
        pats[6] = 64'h1 << 31;
        pats[7] = 64'h1 << 32;
        pats[8] = 64'hF0F0_0FF0_3C3C_C33C;
        pats[9] = 64'h0123_4567_89AB_CDEF;
        for (int p = 0; p < 10; p++) begin
            load(pats[p]);
            sweep(pats[p], "directed");
        end

        for (int r = 0; r < 6; r++) begin
            t = {$urandom(), $urandom()};
            load(t);
            sweep(t, "random");
            drain(t);
            sweep(64'h0, "R2 drained");
        end

        // R3: enable low, input toggling, table must hold
        t = {$urandom(), $urandom()};
        load(t);
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            cfg_din = ~cfg_din;
            cfg_en  = 1'b0;
        end
        @(negedge clk);
        check("R3", "cfg_dout held", cfg_dout, t[0]);
        sweep(t, "R3 hold");

        // R2: mid-chain partial shift of ones
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            cfg_din = 1'b1;
            cfg_en  = 1'b1;
        end
        @(negedge clk);
        cfg_en = 1'b0;
        t = {5'b11111, t[63:5]};
        sweep(t, "R2 partial");

        // R1: reset after a loaded table
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R1", "cfg_dout after re-reset", cfg_dout, 1'b0);
        sweep(64'h0, "R1 re-reset");

        finish_run();
    end
endmodule